// File: doc/BRIEF.md
# Vectored Priority Interrupt Controller

This block decides which exception a CPU core takes next. It watches a set of trap lines that cannot be masked and a larger set of interrupt lines. Each interrupt line has its own enable bit and a 3-bit priority code written by software. The block compares every pending request with the priority the CPU is running at and picks one winner. It then offers the core a registered vector number together with a take strobe.

The core answers with an acknowledge. If the winning line is still requested at that moment, the block raises the running priority to the winner's level and saves the old level on a small internal stack. A return strobe from the core pops that level back. Traps run at a level above all seven interrupt levels. Traps are still offered while a trap handler runs, so any pending trap preempts. When the stack is full, nothing is offered until a return frees a slot.

Top module: `exc_arbiter`

## Requirements
- R1: After reset, `take` is 0 and `cpu_pri` is 0.
- R2: If any trap line is high, the offered vector is the index of the lowest-numbered trap that is high (vectors 0..NTRAP-1), whatever the interrupt lines show.
- R3: Interrupt n is a candidate only if all of these hold: it is requested, its enable bit is 1, and its priority code (bits 3n+2..3n of `irq_pri`) is strictly greater than `cpu_pri`. A code of 0 or a clear enable bit never makes a candidate. Its vector is NTRAP+n.
- R4: Among interrupt candidates, the highest priority code wins. On a tie in code, the lowest source number wins.
- R5: Arbitration is registered. `take` and `vec` reflect the inputs sampled at the previous rising clock edge.
- R6: An `ack` given while `take` is 1 is rejected when the offered line is no longer requested (or, for an interrupt, no longer enabled). `cpu_pri` stays unchanged, and an `ack` while `take` is 0 is also ignored.
- R7: An accepted `ack` sets `cpu_pri` to the winner's level on the next edge: the priority code for an interrupt, 8 for a trap. `take` is 0 in the cycle after acceptance.
- R8: `reti` pops the most recently saved level into `cpu_pri`. With nothing saved, `reti` leaves `cpu_pri` unchanged.
- R9: While DEPTH levels are saved, `take` stays 0 even with traps pending, until a `reti` frees a slot.
- R10: Traps are offered at every running level, including level 8 inside a trap handler.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| trap_req | input | NTRAP | Non-maskable trap request lines |
| irq_req | input | NIRQ | Interrupt request lines |
| irq_en | input | NIRQ | Per-interrupt enable bits |
| irq_pri | input | 3*NIRQ | Per-interrupt priority codes, 3 bits each |
| ack | input | 1 | Core accepts the offered exception |
| reti | input | 1 | Core returns from a handler |
| take | output | 1 | An exception is offered |
| vec | output | clog2(NTRAP+NIRQ) | Offered vector number |
| cpu_pri | output | 4 | Running priority level, 0..8 |

## Verification
The bench builds the block with NTRAP=2, NIRQ=6 and DEPTH=3. At this size it can sweep every combination of the six request lines. The priority codes and enable masks are rotated between passes, at running level 0 and again at level 5, so ties, disabled sources and below-level sources all occur. The shallow stack means a nesting chain of interrupt, interrupt and trap fills it. This reaches the full-stack hold, the withdrawn-acknowledge rejection, the return on an empty stack, and a trap preempting a trap at level 8.

// File: rtl/exc_arbiter.sv
`timescale 1ns/1ps
module exc_arbiter #(
  parameter int NTRAP = 8,
  parameter int NIRQ  = 118,
  parameter int DEPTH = 8
) (
  input  logic                                  clk,
  input  logic                                  rst_n,
  input  logic [NTRAP-1:0]                      trap_req,
  input  logic [NIRQ-1:0]                       irq_req,
  input  logic [NIRQ-1:0]                       irq_en,
  input  logic [3*NIRQ-1:0]                     irq_pri,
  input  logic                                  ack,
  input  logic                                  reti,
  output logic                                  take,
  output logic [$clog2(NTRAP+NIRQ)-1:0]         vec,
  output logic [3:0]                            cpu_pri
);
  localparam int NSRC = NTRAP + NIRQ;
  localparam int VW   = $clog2(NSRC);
  localparam int PW   = $clog2(DEPTH + 1);
  localparam logic [3:0] TRAP_LVL = 4'd8;

  logic          w_ok;
  logic [VW-1:0] w_vec;
  logic [3:0]    w_lvl;
  logic [3:0]    best;
  logic          take_q;
  logic [VW-1:0] vec_q;
  logic [3:0]    lvl_q;
  logic [3:0]    cur_q;
  logic [3:0]    stk [DEPTH];
  logic [PW-1:0] ptr;
  logic [3:0]    top;
  logic          still;
  logic          accepted;
  logic          full;
  logic          pop;

  always_comb begin
    w_ok  = 1'b0;
    w_vec = '0;
    w_lvl = '0;
    best  = '0;
    for (int n = NIRQ - 1; n >= 0; n--) begin
      if (irq_req[n] && irq_en[n] &&
          ({1'b0, irq_pri[3*n +: 3]} > cur_q) &&
          ({1'b0, irq_pri[3*n +: 3]} >= best)) begin
        best  = {1'b0, irq_pri[3*n +: 3]};
        w_ok  = 1'b1;
        w_vec = VW'(NTRAP + n);
        w_lvl = {1'b0, irq_pri[3*n +: 3]};
      end
    end
    for (int t = NTRAP - 1; t >= 0; t--) begin
      if (trap_req[t]) begin
        w_ok  = 1'b1;
        w_vec = VW'(t);
        w_lvl = TRAP_LVL;
      end
    end
  end

  always_comb begin
    still = 1'b0;
    for (int t = 0; t < NTRAP; t++)
      if (vec_q == VW'(t)) still = trap_req[t];
    for (int n = 0; n < NIRQ; n++)
      if (vec_q == VW'(NTRAP + n)) still = irq_req[n] && irq_en[n];
  end

  always_comb begin
    top = '0;
    for (int i = 0; i < DEPTH; i++)
      if (ptr == PW'(i + 1)) top = stk[i];
  end

  assign accepted = take_q && ack && still;
  assign full     = (ptr == PW'(DEPTH));
  assign pop      = reti && !accepted && (ptr != '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      take_q <= 1'b0;
      vec_q  <= '0;
      lvl_q  <= '0;
      cur_q  <= '0;
      ptr    <= '0;
      for (int i = 0; i < DEPTH; i++) stk[i] <= '0;
    end else begin
      take_q <= w_ok && !full && !accepted;
      vec_q  <= w_vec;
      lvl_q  <= w_lvl;
      if (accepted) begin
        cur_q <= lvl_q;
        ptr   <= ptr + PW'(1);
        for (int i = 0; i < DEPTH; i++)
          if (ptr == PW'(i)) stk[i] <= cur_q;
      end else if (pop) begin
        cur_q <= top;
        ptr   <= ptr - PW'(1);
      end
    end
  end

  assign take    = take_q;
  assign vec     = vec_q;
  assign cpu_pri = cur_q;

  a_r7_raise: assert property (@(posedge clk) disable iff (!rst_n)
    accepted |=> cpu_pri == $past(lvl_q));
  a_r7_drop: assert property (@(posedge clk) disable iff (!rst_n)
    accepted |=> !take);
  a_r9_full_hold: assert property (@(posedge clk) disable iff (!rst_n)
    full |=> !take);
  a_r8_pop: assert property (@(posedge clk) disable iff (!rst_n)
    pop |=> cpu_pri == $past(top));
  a_r10_ceiling: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_pri <= TRAP_LVL);
  a_r3_above_level: assert property (@(posedge clk) disable iff (!rst_n)
    (take && vec >= VW'(NTRAP)) |-> lvl_q > cpu_pri);
endmodule

// File: tb/exc_arbiter_bench.sv
`timescale 1ns/1ps
module exc_arbiter_bench;
  localparam int NT = 2;
  localparam int NI = 6;
  localparam int VW = $clog2(NT + NI);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [NT-1:0]   trap_req = '0;
  logic [NI-1:0]   irq_req = '0;
  logic [NI-1:0]   irq_en = '0;
  logic [3*NI-1:0] irq_pri = '0;
  logic ack = 1'b0;
  logic reti = 1'b0;
  logic take;
  logic [VW-1:0] vec;
  logic [3:0] cpu_pri;
  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  exc_arbiter #(.NTRAP(NT), .NIRQ(NI), .DEPTH(3)) u_exc_arbiter (
    .clk(clk), .rst_n(rst_n), .trap_req(trap_req), .irq_req(irq_req),
    .irq_en(irq_en), .irq_pri(irq_pri), .ack(ack), .reti(reti),
    .take(take), .vec(vec), .cpu_pri(cpu_pri));

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic check(input string tag, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic model(input int lvl, output int ok, output int v);
    int bp;
    ok = 0; v = 0; bp = 0;
    for (int t = 0; t < NT; t++)
      if (ok == 0 && trap_req[t]) begin ok = 1; v = t; end
    if (ok == 0)
      for (int n = 0; n < NI; n++) begin
        int p;
        p = int'(irq_pri[3*n +: 3]);
        if (irq_req[n] && irq_en[n] && p > lvl && p > bp) begin
          bp = p; ok = 1; v = NT + n;
        end
      end
  endtask

  task automatic sweep(input int lvl, input int passes, input string tag);
    for (int s = 0; s < passes; s++)
      for (int m = 0; m < 64; m++) begin
        int ok, v;
        for (int n = 0; n < NI; n++) irq_pri[3*n +: 3] = 3'((n*3 + m + s*5) % 8);
        irq_en  = (s == 3) ? 6'b111010 : 6'b111111;
        irq_req = 6'(m);
        trap_req = '0;
        tick();
        model(lvl, ok, v);
        check({tag, " take"}, int'(take), ok);
        if (ok == 1) check({tag, " vec"}, int'(vec), v);
      end
  endtask

  initial begin
    repeat (3) tick();
    check("R1 take after reset", int'(take), 0);
    check("R1 cpu_pri after reset", int'(cpu_pri), 0);
    rst_n = 1'b1;
    tick();
    check("R1 idle take", int'(take), 0);

    sweep(0, 4, "R3 R4 R5 sweep lvl0");

    for (int t = 1; t < 4; t++) begin
      irq_req = 6'h3F; irq_en = 6'h3F; irq_pri = {NI{3'd7}};
      trap_req = 2'(t);
      tick();
      check("R2 trap take", int'(take), 1);
      check("R2 trap vec", int'(vec), (t & 1) ? 0 : 1);
    end

    trap_req = '0; irq_req = 6'b000100; irq_en = 6'h3F;
    irq_pri = '0; irq_pri[3*2 +: 3] = 3'd5;
    tick();
    check("R5 offer irq2", int'(take), 1);
    check("R3 vec irq2", int'(vec), NT + 2);
    ack = 1'b1; tick(); ack = 1'b0;
    check("R7 raise to 5", int'(cpu_pri), 5);
    check("R7 take drops", int'(take), 0);
    tick();
    check("R3 equal level not taken", int'(take), 0);

    sweep(5, 2, "R3 R4 sweep lvl5");

    irq_req = 6'b010000; irq_en = 6'h3F;
    irq_pri = '0; irq_pri[3*4 +: 3] = 3'd7;
    tick();
    check("R4 offer irq4", int'(vec), NT + 4);
    ack = 1'b1; tick(); ack = 1'b0;
    check("R7 raise to 7", int'(cpu_pri), 7);
    irq_req = '0; trap_req = 2'b10;
    tick();
    check("R10 trap at lvl7", int'(take), 1);
    check("R2 trap1 vec", int'(vec), 1);
    ack = 1'b1; tick(); ack = 1'b0;
    check("R7 trap raises to 8", int'(cpu_pri), 8);
    tick();
    check("R9 full holds take", int'(take), 0);
    tick();
    check("R9 full still holds", int'(take), 0);
    reti = 1'b1; tick(); reti = 1'b0;
    check("R8 pop to 7", int'(cpu_pri), 7);
    tick();
    check("R9 offer after slot frees", int'(take), 1);
    trap_req = '0; ack = 1'b1; tick(); ack = 1'b0;
    check("R6 withdrawn ack rejected", int'(cpu_pri), 7);
    ack = 1'b1; tick(); ack = 1'b0;
    check("R6 ack without take ignored", int'(cpu_pri), 7);
    reti = 1'b1; tick();
    check("R8 pop to 5", int'(cpu_pri), 5);
    tick();
    check("R8 pop to 0", int'(cpu_pri), 0);
    tick(); reti = 1'b0;
    check("R8 empty pop ignored", int'(cpu_pri), 0);

    rst_n = 1'b0; tick(); tick(); rst_n = 1'b1;
    trap_req = 2'b01; tick();
    check("R2 trap0 vec", int'(vec), 0);
    ack = 1'b1; tick(); ack = 1'b0;
    check("R7 trap0 raises to 8", int'(cpu_pri), 8);
    trap_req = 2'b10; tick();
    check("R10 trap at lvl8 take", int'(take), 1);
    check("R10 trap at lvl8 vec", int'(vec), 1);

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #2000000;
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule